// File: doc/BRIEF.md
# Transmit DMA Channel with Interrupt Status

This block is one memory-to-serial DMA channel. Software programs a 64-bit buffer pointer, a maximum burst size and an attribute word through a small register slave. Writing the byte count starts the channel. It then issues word-aligned burst read requests on a simple memory port and forwards each returned 32-bit beat into the transmit FIFO of a serial engine. The last beat of a transfer carries a byte-valid mask.

Completion, end-of-buffer and bus-error conditions are latched in a write-1-to-clear status register. One interrupt line is the OR of the status bits gated by an enable mask. The enable mask is never written directly: it changes only through a set address and a clear address, and a read-only address shows its current value. A bus error stops the channel, and the bytes that were not delivered remain readable.

Register word index (byte offset >> 2): 0 pointer low, 1 pointer high, 2 attribute (bit 0 = end-of-buffer), 3 byte count, 4 maximum burst in beats, 5 enable set, 6 enable clear, 7 enable view (read-only), 8 status, 9 remaining bytes (read-only), 10 busy (read-only, bit 0).

Top module: `sdma_txch`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and no memory request is presented.
- R2: A write to the enable-set address ORs its low 3 bits into the enable mask. A write to the enable-clear address removes the bits that are 1. The enable view address returns the mask.
- R3: A byte-count write while the channel is idle starts a transfer. Requests start at the pointer with bits [1:0] forced to zero and advance by 4 bytes per beat. Each request asks for min(remaining words, maximum burst) beats, and a programmed maximum burst of 0 acts as 1.
- R4: Returned beats are pushed to the FIFO in order with their data unchanged. `fifo_be` is 4'hF except on the last beat of a count that is not a multiple of 4, where it is 4'h1, 4'h3 or 4'h7 for 1, 2 or 3 remaining bytes.
- R5: When the last byte is delivered, status bit 0 (done) is set and the channel goes idle. Status bit 1 (end-of-transfer) is set at the same time only if attribute bit 0 was 1 when the transfer started.
- R6: A beat that returns with `mem_rsp_err` high is not pushed. It stops the channel, sets status bit 2 and does not set done. The remaining-bytes register then holds the count that was not delivered.
- R7: A byte-count write while busy is ignored: the count, the remaining bytes and the transfer are unchanged. The write sets status bit 3, which is sticky until cleared.
- R8: Status bits are write-1-to-clear. Writing all ones clears every pending bit. A new event in the same cycle as a clear wins.
- R9: `irq` is high exactly when some status bit in [2:0] has its enable bit set.
- R10: A request is presented only while `fifo_free` is at least the beat count of that burst.
- R11: A byte count of 0 sets done, and sets end-of-transfer when attribute bit 0 is 1, without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req_valid | output | 1 | Burst read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Word-aligned start address of the burst |
| mem_req_beats | output | BURST_W | Beats requested |
| mem_rsp_valid | input | 1 | Read beat valid |
| mem_rsp_data | input | 32 | Read beat data |
| mem_rsp_err | input | 1 | Beat returned with a bus error |
| fifo_free | input | FREE_W | Free word slots in the transmit FIFO |
| fifo_push | output | 1 | Write one word into the FIFO |
| fifo_data | output | 32 | FIFO write data |
| fifo_be | output | 4 | Byte-valid mask of the pushed word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with a 12-bit byte count, a 3-bit burst field (bursts of at most 7 beats) and a 5-bit FIFO-room input. With a short count and a small burst cap, one transfer can need several bursts, so burst splitting, a burst value of 0, and partial last beats of 1, 2 and 3 bytes can all be reached in a few dozen cycles. The bench holds the FIFO-room input below and then at the burst size to stall and release a request. It also injects an error in the middle of a burst.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;
  // Register word indices (byte address bits [5:2]).
  localparam logic [3:0] RI_PTR_LO  = 4'd0;
  localparam logic [3:0] RI_PTR_HI  = 4'd1;
  localparam logic [3:0] RI_ATTR    = 4'd2;
  localparam logic [3:0] RI_COUNT   = 4'd3;
  localparam logic [3:0] RI_BURST   = 4'd4;
  localparam logic [3:0] RI_IEN_SET = 4'd5;
  localparam logic [3:0] RI_IEN_CLR = 4'd6;
  localparam logic [3:0] RI_IEN     = 4'd7;
  localparam logic [3:0] RI_STATUS  = 4'd8;
  localparam logic [3:0] RI_REMAIN  = 4'd9;
  localparam logic [3:0] RI_BUSY    = 4'd10;

  // Status / enable bit positions.
  localparam int SB_DONE    = 0;
  localparam int SB_EOT     = 1;
  localparam int SB_BUSERR  = 2;
  localparam int SB_RESTART = 3;
  localparam int N_IRQ      = 3;
  localparam int N_STAT     = 4;

  typedef enum logic [1:0] {CH_IDLE, CH_REQ, CH_DATA} ch_state_e;
endpackage

// File: rtl/sdma_engine.sv
`timescale 1ns/1ps
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int BURST_W = 5,
  parameter int FREE_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   start_len_i,
  input  logic [63:0]        start_addr_i,
  input  logic [BURST_W-1:0] max_burst_i,
  input  logic [FREE_W-1:0]  fifo_free_i,
  input  logic               req_ready_i,
  input  logic               rsp_valid_i,
  input  logic               rsp_err_i,
  output logic               req_valid_o,
  output logic [63:0]        req_addr_o,
  output logic [BURST_W-1:0] req_beats_o,
  output logic               push_o,
  output logic [3:0]         be_o,
  output logic               busy_o,
  output logic [LEN_W-1:0]   rem_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int WW = LEN_W + 1;

  // Beats for the next burst: remaining words capped by the burst limit (0 -> 1).
  function automatic logic [BURST_W-1:0] burst_beats(input logic [LEN_W-1:0] rem,
                                                     input logic [BURST_W-1:0] mb);
    logic [WW-1:0] words;
    logic [BURST_W-1:0] cap;
    words = ({1'b0, rem} + WW'(3)) >> 2;
    cap   = (mb == '0) ? BURST_W'(1) : mb;
    if (words > WW'(cap)) return cap;
    else                  return words[BURST_W-1:0];
  endfunction

  // Byte-valid mask of a beat given the bytes still owed.
  function automatic logic [3:0] beat_mask(input logic [LEN_W-1:0] rem);
    if (rem >= LEN_W'(4)) return 4'hF;
    case (rem[1:0])
      2'd1:    return 4'h1;
      2'd2:    return 4'h3;
      2'd3:    return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  ch_state_e          st_q;
  logic [63:0]        addr_q;
  logic [LEN_W-1:0]   rem_q;
  logic [BURST_W-1:0] left_q;
  logic [BURST_W-1:0] cur_beats;
  logic               take, good, last_beat, hs;

  assign cur_beats   = burst_beats(rem_q, max_burst_i);
  assign req_valid_o = (st_q == CH_REQ) && (int'(fifo_free_i) >= int'(cur_beats));
  assign req_addr_o  = addr_q;
  assign req_beats_o = cur_beats;
  assign hs          = req_valid_o && req_ready_i;

  assign take      = (st_q == CH_DATA) && rsp_valid_i;
  assign good      = take && !rsp_err_i;
  assign last_beat = rem_q <= LEN_W'(4);
  assign push_o    = good;
  assign be_o      = beat_mask(rem_q);
  assign err_o     = take && rsp_err_i;
  assign done_o    = (start_i && (start_len_i == '0)) || (good && last_beat);
  assign busy_o    = (st_q != CH_IDLE);
  assign rem_o     = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      left_q <= '0;
    end else begin
      case (st_q)
        CH_IDLE: if (start_i) begin
          addr_q <= {start_addr_i[63:2], 2'b00};
          rem_q  <= start_len_i;
          if (start_len_i != '0) st_q <= CH_REQ;
        end
        CH_REQ: if (hs) begin
          left_q <= cur_beats;
          st_q   <= CH_DATA;
        end
        default: begin
          if (err_o) begin
            st_q <= CH_IDLE;
          end else if (good) begin
            rem_q  <= last_beat ? '0 : rem_q - LEN_W'(4);
            addr_q <= addr_q + 64'd4;
            left_q <= left_q - BURST_W'(1);
            if (last_beat)                 st_q <= CH_IDLE;
            else if (left_q == BURST_W'(1)) st_q <= CH_REQ;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdma_regs.sv
`timescale 1ns/1ps
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int BURST_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [5:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               busy_i,
  input  logic [LEN_W-1:0]   rem_i,
  input  logic               done_i,
  input  logic               err_i,
  output logic               start_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [63:0]        addr_o,
  output logic [BURST_W-1:0] burst_o,
  output logic               ien_wr_o,
  output logic               restart_err_o,
  output logic               irq_o
);
  logic [31:0]        ptr_lo_q, ptr_hi_q;
  logic               attr_q, eot_armed_q, eot_src;
  logic [LEN_W-1:0]   len_q;
  logic [BURST_W-1:0] burst_q;
  logic [N_IRQ-1:0]   ien_q;
  logic [N_STAT-1:0]  stat_q, stat_set, stat_clr;
  logic [3:0]         idx;
  logic               wr_count;

  assign idx           = addr_i[5:2];
  assign wr_count      = we_i && (idx == RI_COUNT);
  assign start_o       = wr_count && !busy_i;
  assign restart_err_o = wr_count && busy_i;
  assign ien_wr_o      = we_i && (idx == RI_IEN_SET);
  assign len_o         = wdata_i[LEN_W-1:0];
  assign addr_o        = {ptr_hi_q, ptr_lo_q};
  assign burst_o       = burst_q;

  assign eot_src  = start_o ? attr_q : eot_armed_q;
  assign stat_set = {restart_err_o, err_i, done_i && eot_src, done_i};
  assign stat_clr = (we_i && (idx == RI_STATUS)) ? wdata_i[N_STAT-1:0] : '0;
  assign irq_o    = |(stat_q[N_IRQ-1:0] & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo_q    <= '0;
      ptr_hi_q    <= '0;
      attr_q      <= 1'b0;
      eot_armed_q <= 1'b0;
      len_q       <= '0;
      burst_q     <= '0;
      ien_q       <= '0;
      stat_q      <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (start_o) eot_armed_q <= attr_q;
      if (we_i) begin
        case (idx)
          RI_PTR_LO:  ptr_lo_q <= wdata_i;
          RI_PTR_HI:  ptr_hi_q <= wdata_i;
          RI_ATTR:    attr_q   <= wdata_i[0];
          RI_COUNT:   if (!busy_i) len_q <= wdata_i[LEN_W-1:0];
          RI_BURST:   burst_q  <= wdata_i[BURST_W-1:0];
          RI_IEN_SET: ien_q    <= ien_q | wdata_i[N_IRQ-1:0];
          RI_IEN_CLR: ien_q    <= ien_q & ~wdata_i[N_IRQ-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      RI_PTR_LO: rdata_o = ptr_lo_q;
      RI_PTR_HI: rdata_o = ptr_hi_q;
      RI_ATTR:   rdata_o = 32'(attr_q);
      RI_COUNT:  rdata_o = 32'(len_q);
      RI_BURST:  rdata_o = 32'(burst_q);
      RI_IEN:    rdata_o = 32'(ien_q);
      RI_STATUS: rdata_o = 32'(stat_q);
      RI_REMAIN: rdata_o = 32'(rem_i);
      RI_BUSY:   rdata_o = 32'(busy_i);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sdma_txch.sv
`timescale 1ns/1ps
module sdma_txch
  import sdma_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int BURST_W = 5,
  parameter int FREE_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [5:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [63:0]        mem_req_addr,
  output logic [BURST_W-1:0] mem_req_beats,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  input  logic               mem_rsp_err,
  input  logic [FREE_W-1:0]  fifo_free,
  output logic               fifo_push,
  output logic [31:0]        fifo_data,
  output logic [3:0]         fifo_be,
  output logic               irq
);
  // Named internal events, also observed by the bound checker.
  logic               ev_start, ev_done, ev_err, ev_restart_err, ien_wr;
  logic               busy_w;
  logic [LEN_W-1:0]   rem_w, start_len_w;
  logic [63:0]        start_addr_w;
  logic [BURST_W-1:0] burst_w;

  assign fifo_data = mem_rsp_data;

  sdma_regs #(.LEN_W(LEN_W), .BURST_W(BURST_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy_w),
    .rem_i(rem_w), .done_i(ev_done), .err_i(ev_err),
    .start_o(ev_start), .len_o(start_len_w), .addr_o(start_addr_w),
    .burst_o(burst_w), .ien_wr_o(ien_wr), .restart_err_o(ev_restart_err),
    .irq_o(irq)
  );

  sdma_engine #(.LEN_W(LEN_W), .BURST_W(BURST_W), .FREE_W(FREE_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .start_i(ev_start), .start_len_i(start_len_w),
    .start_addr_i(start_addr_w), .max_burst_i(burst_w), .fifo_free_i(fifo_free),
    .req_ready_i(mem_req_ready), .rsp_valid_i(mem_rsp_valid), .rsp_err_i(mem_rsp_err),
    .req_valid_o(mem_req_valid), .req_addr_o(mem_req_addr), .req_beats_o(mem_req_beats),
    .push_o(fifo_push), .be_o(fifo_be), .busy_o(busy_w), .rem_o(rem_w),
    .done_o(ev_done), .err_o(ev_err)
  );
endmodule

// File: rtl/sdma_txch_chk.sv
`timescale 1ns/1ps
module sdma_txch_chk #(
  parameter int BURST_W = 5,
  parameter int FREE_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req_valid,
  input logic [63:0]        mem_req_addr,
  input logic [BURST_W-1:0] mem_req_beats,
  input logic [FREE_W-1:0]  fifo_free,
  input logic               fifo_push,
  input logic [3:0]         fifo_be,
  input logic               busy,
  input logic               ev_done,
  input logic               ev_err,
  input logic               ien_wr,
  input logic               irq
);
  // R3: requests are word aligned and never empty
  a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00) && (mem_req_beats != '0));

  // R4: byte mask is a contiguous run from byte 0
  a_r4_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $onehot({1'b0, fifo_be} + 5'd1));

  // R10: no request without room for the whole burst
  a_r10_room: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (int'(fifo_free) >= int'(mem_req_beats)));

  // R6: a bus error leaves the channel idle
  a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> !busy);

  // R5: completion leaves the channel idle
  a_r5_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !busy);

  // R9: the interrupt only rises after an event or an enable write
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_done || ev_err || ien_wr));
endmodule

bind sdma_txch sdma_txch_chk #(.BURST_W(BURST_W), .FREE_W(FREE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_req_beats(mem_req_beats),
  .fifo_free(fifo_free), .fifo_push(fifo_push), .fifo_be(fifo_be),
  .busy(busy_w), .ev_done(ev_done), .ev_err(ev_err), .ien_wr(ien_wr),
  .irq(irq)
);

// File: tb/sdma_txch_tb.sv
`timescale 1ns/1ps
module sdma_txch_tb_top;
  localparam int LEN_W = 12, BURST_W = 3, FREE_W = 5;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_ATTR = 6'h08, A_CNT = 6'h0C,
                         A_BUR = 6'h10, A_SET = 6'h14, A_CLR = 6'h18, A_IEN = 6'h1C,
                         A_STA = 6'h20, A_REM = 6'h24, A_BSY = 6'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic [BURST_W-1:0] mem_req_beats;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0, fifo_data;
  logic [FREE_W-1:0] fifo_free = 5'd31;
  logic fifo_push, irq;
  logic [3:0] fifo_be;

  always #2 clk = ~clk;

  sdma_txch #(.LEN_W(LEN_W), .BURST_W(BURST_W), .FREE_W(FREE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_beats(mem_req_beats), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .fifo_free(fifo_free),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_be(fifo_be), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] req_a [64];
  int          req_n [64];
  logic [31:0] psh_d [64];
  logic [3:0]  psh_b [64];
  int n_req = 0, n_push = 0, beat_cnt = 0, err_beat = -1;
  logic [63:0] q_addr = '0;
  int q_left = 0;

  function automatic logic [31:0] mdat(input logic [63:0] a);
    return a[31:0] ^ 32'hC3A5_0000 ^ {a[39:32], 24'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model and FIFO monitor: drive at negedge, sample 1 ns later.
  always @(negedge clk) begin
    if (q_left > 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mdat(q_addr);
      mem_rsp_err   = (beat_cnt == err_beat);
      q_addr = q_addr + 64'd4;
      q_left = mem_rsp_err ? 0 : q_left - 1;
      beat_cnt++;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
    end
    #1;
    if (fifo_push && n_push < 64) begin
      psh_d[n_push] = fifo_data; psh_b[n_push] = fifo_be; n_push++;
    end
    if (mem_req_valid && mem_req_ready && n_req < 64) begin
      req_a[n_req] = mem_req_addr; req_n[n_req] = int'(mem_req_beats); n_req++;
      q_addr = mem_req_addr; q_left = int'(mem_req_beats);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle_wait;
    logic [31:0] b;
    for (int i = 0; i < 400; i++) begin
      rd(A_BSY, b);
      if (b == 0) break;
    end
  endtask

  task automatic fresh;
    n_req = 0; n_push = 0; beat_cnt = 0; err_beat = -1;
  endtask

  task automatic start(input logic [63:0] a, input int len, input int burst, input bit eot);
    fresh();
    wr(A_LO, a[31:0]); wr(A_HI, a[63:32]); wr(A_ATTR, 32'(eot)); wr(A_BUR, 32'(burst));
    wr(A_CNT, 32'(len));
  endtask

  task automatic check_data(input logic [63:0] base, input int len, input string tag);
    for (int i = 0; i < (len + 3) / 4; i++) begin
      logic [3:0] eb;
      eb = (len - 4*i >= 4) ? 4'hF : 4'((1 << (len - 4*i)) - 1);
      chk(psh_d[i] == mdat(base + 64'(4*i)), {tag, " data"}, 64'(psh_d[i]), 64'(mdat(base + 64'(4*i))));
      chk(psh_b[i] == eb, {tag, " mask"}, 64'(psh_b[i]), 64'(eb));
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (A_LIST[k]) begin
      rd(A_LIST[k], v);
      chk(v == 0, "R1 reg zero", 64'(v), 0);
    end
    chk(irq == 0 && mem_req_valid == 0, "R1 outputs idle", 64'({irq, mem_req_valid}), 0);
  endtask
  localparam logic [5:0] A_LIST [9] = '{A_LO, A_HI, A_ATTR, A_CNT, A_BUR, A_IEN, A_STA, A_REM, A_BSY};

  task automatic t_enables;
    logic [31:0] v;
    wr(A_SET, 32'h5); rd(A_IEN, v); chk(v == 5, "R2 set", 64'(v), 5);
    wr(A_SET, 32'h2); rd(A_IEN, v); chk(v == 7, "R2 set or", 64'(v), 7);
    wr(A_CLR, 32'h4); rd(A_IEN, v); chk(v == 3, "R2 clear", 64'(v), 3);
  endtask

  task automatic t_multi_burst;
    logic [31:0] v;
    start(64'h1_0000_1002, 22, 4, 1'b1); idle_wait();
    chk(n_req == 2, "R3 burst count", 64'(n_req), 2);
    chk(req_a[0] == 64'h1_0000_1000 && req_n[0] == 4, "R3 first burst", req_a[0], 64'h1_0000_1000);
    chk(req_a[1] == 64'h1_0000_1010 && req_n[1] == 2, "R3 second burst", 64'(req_n[1]), 2);
    chk(n_push == 6, "R4 beat count", 64'(n_push), 6);
    check_data(64'h1_0000_1000, 22, "R4 22B");
    rd(A_STA, v); chk(v == 3, "R5 done+eot", 64'(v), 3);
    rd(A_REM, v); chk(v == 0, "R5 remaining zero", 64'(v), 0);
    chk(irq == 1, "R9 irq on", 64'(irq), 1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(A_STA, 32'h1); rd(A_STA, v); chk(v == 2, "R8 w1c one bit", 64'(v), 2);
    chk(irq == 1, "R9 irq by eot", 64'(irq), 1);
    wr(A_STA, 32'hFFFF_FFFF); rd(A_STA, v); chk(v == 0, "R8 all ones", 64'(v), 0);
    chk(irq == 0, "R9 irq off", 64'(irq), 0);
  endtask

  task automatic t_burst_zero;
    logic [31:0] v;
    start(64'h2000, 8, 0, 1'b0); idle_wait();
    chk(n_req == 2 && req_n[0] == 1 && req_n[1] == 1, "R3 burst 0 acts as 1", 64'(n_req), 2);
    chk(req_a[1] == 64'h2004, "R3 address step", req_a[1], 64'h2004);
    check_data(64'h2000, 8, "R4 8B");
    rd(A_STA, v); chk(v == 1, "R5 no eot when attr 0", 64'(v), 1);
    wr(A_STA, 32'hF);
  endtask

  task automatic t_room_and_restart;
    logic [31:0] v;
    fifo_free = 5'd0;
    start(64'h3000, 16, 4, 1'b0);
    repeat (5) @(negedge clk);
    chk(n_req == 0, "R10 held at no room", 64'(n_req), 0);
    rd(A_BSY, v); chk(v == 1, "R3 busy after start", 64'(v), 1);
    wr(A_CNT, 32'd8);
    rd(A_STA, v); chk(v == 8, "R7 restart flag", 64'(v), 8);
    rd(A_CNT, v); chk(v == 16, "R7 count kept", 64'(v), 16);
    rd(A_REM, v); chk(v == 16, "R7 remaining kept", 64'(v), 16);
    fifo_free = 5'd3;
    repeat (5) @(negedge clk);
    chk(n_req == 0, "R10 held at room 3", 64'(n_req), 0);
    fifo_free = 5'd4; idle_wait(); fifo_free = 5'd31;
    chk(n_req == 1 && req_n[0] == 4, "R10 released at room 4", 64'(n_req), 1);
    chk(n_push == 4, "R7 original length sent", 64'(n_push), 4);
    rd(A_STA, v); chk(v == 9, "R7 sticky plus done", 64'(v), 9);
    wr(A_STA, 32'hF);
  endtask

  task automatic t_bus_error;
    logic [31:0] v;
    wr(A_SET, 32'h4);
    fresh(); err_beat = 2;
    wr(A_LO, 32'h4000); wr(A_HI, 0); wr(A_ATTR, 1); wr(A_BUR, 7); wr(A_CNT, 24);
    idle_wait();
    chk(n_req == 1 && req_n[0] == 6, "R3 capped by words", 64'(req_n[0]), 6);
    chk(n_push == 2, "R6 errored beat dropped", 64'(n_push), 2);
    rd(A_STA, v); chk(v == 4, "R6 bus error only", 64'(v), 4);
    rd(A_REM, v); chk(v == 16, "R6 remaining", 64'(v), 16);
    chk(irq == 1, "R9 irq on error", 64'(irq), 1);
    wr(A_STA, 32'hF);
    chk(irq == 0, "R9 irq cleared", 64'(irq), 0);
  endtask

  task automatic t_zero_len;
    logic [31:0] v;
    start(64'h6000, 0, 3, 1'b1);
    repeat (3) @(negedge clk);
    chk(n_req == 0, "R11 no request", 64'(n_req), 0);
    rd(A_STA, v); chk(v == 3, "R11 done+eot", 64'(v), 3);
    wr(A_STA, 32'hF);
  endtask

  task automatic t_tails;
    for (int n = 5; n <= 7; n++) begin
      start(64'h5000 + 64'(n * 64), n, 7, 1'b0); idle_wait();
      chk(n_push == 2, "R4 tail beat count", 64'(n_push), 2);
      check_data(64'h5000 + 64'(n * 64), n, "R4 tail");
      wr(A_STA, 32'hF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_multi_burst();
    t_w1c();
    t_burst_zero();
    t_room_and_restart();
    t_bus_error();
    t_zero_len();
    t_tails();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule